// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block sits between the memory bus write-latch logic and the page write controller of a byte-alterable nonvolatile memory. Every latched write arrives as a one-cycle pulse carrying its address and data byte. The block decides in that same cycle whether the write goes on to the page controller as data. It also keeps the software write-protect flag. That flag is nonvolatile in a real part; here it is a register with a parameterised power-on value.

Two fixed command sequences are recognised. A three-write arming sequence turns protection on, whether or not it was on before. It then opens one page-load window, and the window closes when the page controller reports that programming has finished. A six-write release sequence waits a fixed write-cycle time and then clears protection. While protection is on, writes outside an open window are dropped. Command writes are never forwarded. A write that breaks a sequence half-way returns the matcher to idle and is handled as ordinary data.

Top module: `wps_guard`

## Requirements
- R1: After reset `prot_on` equals the `PROT_INIT` parameter (default 0) and `wr_allow` is low.
- R2: With protection off and no sequence in progress, an ordinary write raises `wr_allow` in the same cycle as its `wr_pulse`, and `wr_allow` is never high without `wr_pulse`.
- R3: The writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555, in that order, set `prot_on` on the clock edge of the third write, whatever its prior value. None of the three raises `wr_allow`.
- R4: After the arming sequence every write raises `wr_allow` until a cycle with `prog_done` high. That cycle is still inside the window. The window then closes with protection on.
- R5: While `prot_on` is high and no window is open, ordinary writes leave `wr_allow` low.
- R6: The writes 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA and 0x20/0x5555 clear `prot_on` exactly `TWC_CYC` clock edges after the edge of the last write. None of the six writes, and no write during that wait, raises `wr_allow`.
- R7: A write that does not match the next expected step returns the matcher to idle. That write is forwarded if protection is off and dropped if it is on. The earlier command writes of the broken sequence are not forwarded, and a later 0xA0/0x5555 on its own does not open a window.
- R8: Only address bits 14:0 take part in command matching; higher address bits are ignored.
- R9: `prog_done` outside an open window changes neither `prot_on` nor the forwarding of later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power-on |
| wr_pulse | input | 1 | One-cycle strobe of a latched bus write |
| wr_addr | input | ADDR_W | Address of the latched write |
| wr_data | input | 8 | Data byte of the latched write |
| prog_done | input | 1 | Page write controller finished its programming cycle |
| wr_allow | output | 1 | Forward this write to the page write controller |
| prot_on | output | 1 | Software write protection is active |

## Verification
The embedded properties check on every cycle that nothing is forwarded without a strobe or while protection is on outside a window. They also check that writes advancing a command sequence are held back, and that the flag rises only on an 0xA0 write and falls only at the end of a release wait. Only the bench scenarios can show that the exact address/data order is needed, that breaking writes lose the held commands, and how long the release wait lasts. They also show that the upper address bits are ignored and that a stray `prog_done` has no effect; a bench reference model follows the protocol through constrained random traffic mixed with whole sequences.

// File: rtl/wps_pkg.sv
package wps_pkg;

  localparam int KEY_AW = 15;
  localparam int DATA_W = 8;
  localparam int N_STEP = 5;

  // Index of each command step in the hit vector
  localparam int K_AA_LO = 0;
  localparam int K_55_HI = 1;
  localparam int K_A0_LO = 2;
  localparam int K_80_LO = 3;
  localparam int K_20_LO = 4;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_U1    = 3'd1,
    SQ_U2    = 3'd2,
    SQ_D3    = 3'd3,
    SQ_D4    = 3'd4,
    SQ_D5    = 3'd5,
    SQ_WIN   = 3'd6,
    SQ_DWAIT = 3'd7
  } seq_state_e;

  function automatic logic [KEY_AW-1:0] key_addr(int idx);
    return (idx == K_55_HI) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [DATA_W-1:0] key_data(int idx);
    case (idx)
      K_AA_LO: return 8'hAA;
      K_55_HI: return 8'h55;
      K_A0_LO: return 8'hA0;
      K_80_LO: return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/wps_step_decode.sv
module wps_step_decode
  import wps_pkg::*;
(
  input  logic [KEY_AW-1:0] key_addr_in,
  input  logic [DATA_W-1:0] key_data_in,
  output logic [N_STEP-1:0] hits
);

  // One comparator per command step
  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    assign hits[g] = (key_addr_in == key_addr(g)) && (key_data_in == key_data(g));
  end

endmodule

// File: rtl/wps_prot_keep.sv
module wps_prot_keep #(
  parameter logic PROT_INIT = 1'b0,
  parameter int   TWC_CYC   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic arm_clr,
  output logic prot_q,
  output logic clearing,
  output logic clr_fire
);

  localparam int            CW   = $clog2(TWC_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(TWC_CYC - 1);

  logic          busy_q, busy_d, busy_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          prot_d, prot_en;

  assign clearing = busy_q;
  assign clr_fire = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    busy_en = 1'b0;
    if (arm_clr) begin
      busy_d  = 1'b1;
      cnt_d   = LOAD;
      busy_en = 1'b1;
    end else if (busy_q) begin
      busy_en = 1'b1;
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_comb begin
    prot_d  = prot_q;
    prot_en = 1'b0;
    if (clr_fire) begin
      prot_d  = 1'b0;
      prot_en = 1'b1;
    end else if (set_req) begin
      prot_d  = 1'b1;
      prot_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= PROT_INIT;
    else if (prot_en) prot_q <= prot_d;
  end

  // A new release wait never starts while one is running
  assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !arm_clr);

endmodule

// File: rtl/wps_seq_ctrl.sv
module wps_seq_ctrl
  import wps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [N_STEP-1:0] hits,
  input  logic              prog_done,
  input  logic              prot_q,
  input  logic              clr_fire,
  output seq_state_e        state_q,
  output logic              adv,
  output logic              set_prot,
  output logic              arm_clr,
  output logic              fwd
);

  seq_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    adv      = 1'b0;
    set_prot = 1'b0;
    arm_clr  = 1'b0;
    fwd      = 1'b0;
    unique case (state_q)
      SQ_IDLE: if (wr_pulse) begin
        if (hits[K_AA_LO]) begin state_d = SQ_U1; adv = 1'b1; end
        else fwd = !prot_q;
      end
      SQ_U1: if (wr_pulse) begin
        if (hits[K_55_HI]) begin state_d = SQ_U2; adv = 1'b1; end
        else begin state_d = SQ_IDLE; fwd = !prot_q; end
      end
      SQ_U2: if (wr_pulse) begin
        if (hits[K_A0_LO]) begin
          state_d = SQ_WIN; adv = 1'b1; set_prot = 1'b1;
        end else if (hits[K_80_LO]) begin
          state_d = SQ_D3; adv = 1'b1;
        end else begin
          state_d = SQ_IDLE; fwd = !prot_q;
        end
      end
      SQ_D3: if (wr_pulse) begin
        if (hits[K_AA_LO]) begin state_d = SQ_D4; adv = 1'b1; end
        else begin state_d = SQ_IDLE; fwd = !prot_q; end
      end
      SQ_D4: if (wr_pulse) begin
        if (hits[K_55_HI]) begin state_d = SQ_D5; adv = 1'b1; end
        else begin state_d = SQ_IDLE; fwd = !prot_q; end
      end
      SQ_D5: if (wr_pulse) begin
        if (hits[K_20_LO]) begin
          state_d = SQ_DWAIT; adv = 1'b1; arm_clr = 1'b1;
        end else begin
          state_d = SQ_IDLE; fwd = !prot_q;
        end
      end
      SQ_WIN: begin
        fwd = wr_pulse;
        if (prog_done) state_d = SQ_IDLE;
      end
      SQ_DWAIT: if (clr_fire) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= SQ_IDLE;
    else if (state_en) state_q <= state_d;
  end

  // The arming write always leaves protection set once the window opens
  assert_win_protected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WIN) && $past(state_q == SQ_U2) |-> prot_q);

endmodule

// File: rtl/wps_guard.sv
module wps_guard
  import wps_pkg::*;
#(
  parameter int   ADDR_W    = 16,
  parameter logic PROT_INIT = 1'b0,
  parameter int   TWC_CYC   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_done,
  output logic              wr_allow,
  output logic              prot_on
);

  logic [N_STEP-1:0] hits;
  seq_state_e        seq_state;
  logic              adv, set_prot, arm_clr, fwd;
  logic              clearing, clr_fire;
  logic              unused_hi;

  assign unused_hi = ^wr_addr[ADDR_W-1:KEY_AW];

  wps_step_decode u_decode (
    .key_addr_in (wr_addr[KEY_AW-1:0]),
    .key_data_in (wr_data),
    .hits        (hits)
  );

  wps_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pulse  (wr_pulse),
    .hits      (hits),
    .prog_done (prog_done),
    .prot_q    (prot_on),
    .clr_fire  (clr_fire),
    .state_q   (seq_state),
    .adv       (adv),
    .set_prot  (set_prot),
    .arm_clr   (arm_clr),
    .fwd       (fwd)
  );

  wps_prot_keep #(
    .PROT_INIT (PROT_INIT),
    .TWC_CYC   (TWC_CYC)
  ) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (set_prot),
    .arm_clr  (arm_clr),
    .prot_q   (prot_on),
    .clearing (clearing),
    .clr_fire (clr_fire)
  );

  assign wr_allow = fwd;

  assert_allow_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow |-> wr_pulse);

  assert_cmd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !wr_allow);

  assert_rise_on_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(wr_pulse && (wr_data == 8'hA0)));

  assert_guard_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on && (seq_state != SQ_WIN) |-> !wr_allow);

  assert_drop_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(seq_state == SQ_DWAIT));

  assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !wr_allow);

endmodule

// File: tb/wps_guard_bench.sv
`timescale 1ns/1ps
module wps_guard_bench;

  localparam int TWC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_pulse = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        wr_allow, prot_on;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wps_guard #(.ADDR_W(16), .PROT_INIT(1'b0), .TWC_CYC(TWC)) u_wps_guard (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_allow(wr_allow), .prot_on(prot_on)
  );

  // Reference model: 0 idle,1 U1,2 U2,3 D3,4 D4,5 D5,6 window,7 release wait
  int ms = 0;
  bit mp = 1'b0;
  int mc = 0;

  function automatic bit key(logic [15:0] a, logic [7:0] d, logic [14:0] ka, logic [7:0] kd);
    return (a[14:0] == ka) && (d == kd);
  endfunction

  function automatic bit mstep(bit p, logic [15:0] a, logic [7:0] d, bit dn);
    bit al = 1'b0;
    bit aa5 = key(a, d, 15'h5555, 8'hAA);
    bit s52 = key(a, d, 15'h2AAA, 8'h55);
    case (ms)
      6: begin al = p; if (dn) ms = 0; end
      7: begin mc--; if (mc == 0) begin mp = 1'b0; ms = 0; end end
      default: if (p) begin
        if      (ms == 0 && aa5) ms = 1;
        else if (ms == 1 && s52) ms = 2;
        else if (ms == 2 && key(a, d, 15'h5555, 8'hA0)) begin ms = 6; mp = 1'b1; end
        else if (ms == 2 && key(a, d, 15'h5555, 8'h80)) ms = 3;
        else if (ms == 3 && aa5) ms = 4;
        else if (ms == 4 && s52) ms = 5;
        else if (ms == 5 && key(a, d, 15'h5555, 8'h20)) begin ms = 7; mc = TWC; end
        else begin ms = 0; al = !mp; end
      end
    endcase
    return al;
  endfunction

  task automatic chk(logic got, logic exp, string req, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc(bit p, logic [15:0] a, logic [7:0] d, bit dn, string req);
    bit pb, ea;
    @(negedge clk);
    wr_pulse = p; wr_addr = a; wr_data = d; prog_done = dn;
    #1;
    pb = mp;
    ea = mstep(p, a, d, dn);
    chk(wr_allow, ea, req, "wr_allow");
    chk(prot_on, pb, req, "prot_on");
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 8'h0, 1'b0, req);
  endtask

  task automatic arm_seq(logic [15:0] hi, string req);
    cyc(1'b1, hi | 16'h5555, 8'hAA, 1'b0, req);
    cyc(1'b1, hi | 16'h2AAA, 8'h55, 1'b0, req);
    cyc(1'b1, hi | 16'h5555, 8'hA0, 1'b0, req);
  endtask

  task automatic rel_seq(string req);
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, req);
    cyc(1'b1, 16'h2AAA, 8'h55, 1'b0, req);
    cyc(1'b1, 16'h5555, 8'h80, 1'b0, req);
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, req);
    cyc(1'b1, 16'h2AAA, 8'h55, 1'b0, req);
    cyc(1'b1, 16'h5555, 8'h20, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(1'b0, 16'h0, 8'h0, 1'b0, "R1");
    chk(prot_on, 1'b0, "R1", "reset prot_on");
    chk(wr_allow, 1'b0, "R1", "reset wr_allow");
    // R2 plain write while unprotected
    cyc(1'b1, 16'h1234, 8'h5A, 1'b0, "R2");
    chk(wr_allow, 1'b1, "R2", "plain write");
    // R3 arming from unprotected, R4 window, R5 blocked afterwards
    arm_seq(16'h0, "R3");
    chk(wr_allow, 1'b0, "R3", "arming write held");
    idle(1, "R3");
    chk(prot_on, 1'b1, "R3", "armed");
    cyc(1'b1, 16'h0400, 8'h11, 1'b0, "R4");
    chk(wr_allow, 1'b1, "R4", "window write");
    cyc(1'b1, 16'h0401, 8'h22, 1'b1, "R4");
    chk(wr_allow, 1'b1, "R4", "last window write");
    cyc(1'b1, 16'h0402, 8'h33, 1'b0, "R5");
    chk(wr_allow, 1'b0, "R5", "protected write");
    chk(prot_on, 1'b1, "R5", "still protected");
    // R7 broken sequence while protected
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, "R7");
    cyc(1'b1, 16'h0000, 8'h12, 1'b0, "R7");
    chk(wr_allow, 1'b0, "R7", "breaking write protected");
    cyc(1'b1, 16'h5555, 8'hA0, 1'b0, "R7");
    cyc(1'b1, 16'h0300, 8'h77, 1'b0, "R7");
    chk(wr_allow, 1'b0, "R7", "no window after break");
    // R9 stray completion
    cyc(1'b0, 16'h0, 8'h0, 1'b1, "R9");
    cyc(1'b1, 16'h0301, 8'h78, 1'b0, "R9");
    chk(wr_allow, 1'b0, "R9", "write after stray done");
    chk(prot_on, 1'b1, "R9", "prot after stray done");
    // R6 release sequence and wait
    rel_seq("R6");
    chk(wr_allow, 1'b0, "R6", "release write held");
    idle(2, "R6");
    cyc(1'b1, 16'h0010, 8'h99, 1'b0, "R6");
    chk(wr_allow, 1'b0, "R6", "write during wait");
    idle(TWC - 3, "R6");
    chk(prot_on, 1'b1, "R6", "before wait ends");
    idle(1, "R6");
    chk(prot_on, 1'b0, "R6", "after wait ends");
    // R7 broken sequence while unprotected
    cyc(1'b1, 16'h5555, 8'hAA, 1'b0, "R7");
    cyc(1'b1, 16'h2AAA, 8'h55, 1'b0, "R7");
    chk(wr_allow, 1'b0, "R7", "held command");
    cyc(1'b1, 16'h0100, 8'h33, 1'b0, "R7");
    chk(wr_allow, 1'b1, "R7", "breaking write unprotected");
    // R9 stray completion while unprotected
    cyc(1'b0, 16'h0, 8'h0, 1'b1, "R9");
    cyc(1'b1, 16'h0101, 8'h34, 1'b0, "R9");
    chk(wr_allow, 1'b1, "R9", "unprotected after stray done");
    // R8 upper address bit ignored
    arm_seq(16'h8000, "R8");
    idle(1, "R8");
    chk(prot_on, 1'b1, "R8", "armed with upper bit set");
    cyc(1'b1, 16'h0555, 8'h44, 1'b1, "R8");
    chk(wr_allow, 1'b1, "R8", "window write");
    // Constrained random traffic with injected sequences
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int r;
      if ($urandom % 60 == 0) begin
        if ($urandom % 2 == 0) arm_seq({$urandom % 2 == 0, 15'h0}, "R3");
        else                   rel_seq("R6");
      end
      r = $urandom % 4;
      a = (r == 0) ? 16'h5555 : (r == 1) ? 16'h2AAA : 16'($urandom);
      a[15] = 1'($urandom);
      r = $urandom % 8;
      case (r)
        0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0; 3: d = 8'h80; 4: d = 8'h20;
        default: d = 8'($urandom);
      endcase
      cyc(($urandom % 10) < 6, a, d, ($urandom % 10) == 0, "R7");
    end
    @(negedge clk);
    wr_pulse = 1'b0; prog_done = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule